// File: doc/BRIEF.md
# Double Bus Fault Detector

This block watches the processor's exception-processing phase and tells whether a bus or address error arrives while the processor is still handling an earlier bus error, address error or reset. That second error is a double bus fault. When it is seen, the block latches a fault flag and drives the open-drain halt line active. The processor stays halted until an external reset. Bus arbitration continues to be granted the whole time.

The exception sequencer reports three things: the start of each exception with its kind, the completion of exception processing, and the bus controller's error events. A bus error that comes with a retry indication is a retried cycle. It is never counted, however many times in a row the retry occurs. Errors raised after the completion strobe, which includes errors in the handler itself, are ordinary faults and are left to normal exception handling. Exception kinds are encoded on two bits: 2'b00 for any other kind (interrupt, trap), 2'b01 for a bus error, 2'b10 for an address error and 2'b11 for reset.

Top module: `dfault_guard`

## Requirements
- R1: While rst_n is low, at every rising edge fault_flag, halt_pull and bus_grant are 0.
- R2: Reset arms the detector for the reset exception itself. A counted error after reset is released and before the first exc_done sets fault_flag.
- R3: While an exception of kind 2'b01, 2'b10 or 2'b11 is in progress, a counted error sets fault_flag at the next rising edge. A counted error is addr_err, or bus_err with retry low.
- R4: exc_done ends the exception phase. Errors that arrive after it do not set fault_flag.
- R5: An exc_start of kind 2'b00 does not arm the detector.
- R6: bus_err with retry high is never counted, for any number of consecutive cycles. addr_err is counted whatever the value of retry.
- R7: Once set, fault_flag stays set until rst_n goes low. exc_start, exc_done and errors have no effect on it.
- R8: halt_pull is 1 exactly when fault_flag is 1, in the same cycle.
- R9: bus_grant equals bus_req delayed by one clock, whether or not a fault is latched.
- R10: When exc_start (qualifying kind) and exc_done come in the same cycle, the start wins and the phase stays active. An error in the same cycle as a qualifying exc_start, while idle, is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, synchronous, active low |
| exc_start | input | 1 | Exception processing begins this cycle |
| exc_kind | input | 2 | Kind of the starting exception (00 other, 01 bus error, 10 address error, 11 reset) |
| exc_done | input | 1 | Exception processing completed strobe |
| bus_err | input | 1 | Bus error event from the bus controller |
| addr_err | input | 1 | Address error event |
| retry | input | 1 | Current bus error is a retry request |
| bus_req | input | 1 | Bus arbitration request from another master |
| bus_grant | output | 1 | Bus granted, one cycle after request |
| halt_pull | output | 1 | Enable for pulling the open-drain halt line low |
| fault_flag | output | 1 | Double bus fault latched |

## Verification
The assertions check four things on every cycle. The fault flag never clears without reset. It rises only after a counted error in the previous cycle. It is low after any reset cycle. The grant tracks the request with one cycle of lag. Whether an error counts depends on the exception phase: reset arming, the completion strobe, non-qualifying kinds and the start-versus-done priority. Only the bench's scenarios exercise those cases, and a behavioural reference model is compared on every clock.

// File: rtl/dfg_pkg.sv
// Package: shared exception-kind encoding for the double bus fault detector.
package dfg_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        EXC_OTHER   = 2'b00,
        EXC_BUSERR  = 2'b01,
        EXC_ADDRERR = 2'b10,
        EXC_RESET   = 2'b11
    } exc_kind_e;

    // True for the kinds whose processing phase is guarded.
    function automatic logic kind_guarded(input logic [KIND_W-1:0] k);
        return (k != EXC_OTHER);
    endfunction
endpackage

// File: rtl/dfg_err_qual.sv
// Error qualifier: merges the error sources into one counted-error pulse.
// Assumes retry only ever qualifies a bus error. Address errors always count.
module dfg_err_qual (
    input  logic bus_err,
    input  logic addr_err,
    input  logic retry,
    output logic err_counted
);
    // A retried bus cycle is dropped; anything else counts.
    always_comb begin
        err_counted = addr_err | (bus_err & ~retry);
    end
endmodule

// File: rtl/dfg_phase_track.sv
// Phase tracker: remembers whether a guarded exception is in progress.
// Assumes reset itself starts a guarded (reset) exception.
module dfg_phase_track
    import dfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_start,
    input  logic [KIND_W-1:0] exc_kind,
    input  logic              exc_done,
    output logic              phase_active
);
    logic start_guarded;

    // Decode whether the starting exception is one that arms the detector.
    always_comb begin
        start_guarded = exc_start & kind_guarded(exc_kind);
    end

    // Set on reset or a guarded start, clear on completion; start has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_active <= 1'b1;
        else if (start_guarded)
            phase_active <= 1'b1;
        else if (exc_done)
            phase_active <= 1'b0;
    end
endmodule

// File: rtl/dfg_fault_latch.sv
// Fault latch: sticky double-fault state, cleared only by external reset.
// Assumes phase_active is the registered phase state, so an error that arrives
// with the exception it causes is not counted.
module dfg_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_active,
    input  logic err_counted,
    output logic fault_q
);
    // Latch a counted error seen inside an active phase; hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (phase_active && err_counted)
            fault_q <= 1'b1;
    end
endmodule

// File: rtl/dfg_arb_pass.sv
// Arbitration pass: delays the request to a grant through DELAY registers.
// Independent of the fault state, so arbitration keeps working while halted.
module dfg_arb_pass #(
    parameter int DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic grant
);
    localparam int STAGES = (DELAY < 1) ? 1 : DELAY;

    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Each stage takes the previous one; stage 0 takes the request.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe_q[i] <= 1'b0;
                else if (i == 0)
                    pipe_q[i] <= req;
                else
                    pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // The last stage is the grant.
    always_comb begin
        grant = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/dfault_guard.sv
// Double bus fault detector top. It tracks the guarded exception phase,
// qualifies errors, latches a double fault into a permanent halt and
// passes arbitration through. Assumes synchronous active-low external reset.
module dfault_guard
    import dfg_pkg::*;
#(
    parameter int GRANT_DELAY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_start,
    input  logic [KIND_W-1:0] exc_kind,
    input  logic              exc_done,
    input  logic              bus_err,
    input  logic              addr_err,
    input  logic              retry,
    input  logic              bus_req,
    output logic              bus_grant,
    output logic              halt_pull,
    output logic              fault_flag
);
    logic err_counted;
    logic phase_active;
    logic fault_q;

    dfg_err_qual u_qual (
        .bus_err     (bus_err),
        .addr_err    (addr_err),
        .retry       (retry),
        .err_counted (err_counted)
    );

    dfg_phase_track u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_start    (exc_start),
        .exc_kind     (exc_kind),
        .exc_done     (exc_done),
        .phase_active (phase_active)
    );

    dfg_fault_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_active (phase_active),
        .err_counted  (err_counted),
        .fault_q      (fault_q)
    );

    dfg_arb_pass #(.DELAY(GRANT_DELAY)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_req),
        .grant (bus_grant)
    );

    // Drive the halt line and the flag from the latched fault.
    always_comb begin
        fault_flag = fault_q;
        halt_pull  = fault_q;
    end
endmodule

// File: rtl/dfg_checks.sv
// Checker for dfault_guard: port-level properties over time.
module dfg_checks #(
    parameter int GRANT_DELAY = 1
) (
    input logic clk,
    input logic rst_n,
    input logic bus_err,
    input logic addr_err,
    input logic retry,
    input logic bus_req,
    input logic bus_grant,
    input logic fault_flag
);
    // R1: a reset cycle leaves the fault flag clear.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !fault_flag);

    // R7: the fault flag never drops without reset.
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> fault_flag);

    // R6: a fault rises only after a counted error in the previous cycle.
    assert_rise_needs_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> $past(addr_err || (bus_err && !retry)));

    generate
        if (GRANT_DELAY == 1) begin : g_grant_chk
            // R9: the grant follows the request by one clock.
            assert_grant_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n && $past(rst_n) |-> bus_grant == $past(bus_req));
        end
    endgenerate
endmodule

bind dfault_guard dfg_checks #(.GRANT_DELAY(GRANT_DELAY)) u_dfg_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_err    (bus_err),
    .addr_err   (addr_err),
    .retry      (retry),
    .bus_req    (bus_req),
    .bus_grant  (bus_grant),
    .fault_flag (fault_flag)
);

// File: tb/dfault_guard_tb_top.sv
module dfault_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exc_start = 1'b0;
    logic [1:0] exc_kind = 2'b00;
    logic       exc_done = 1'b0;
    logic       bus_err = 1'b0;
    logic       addr_err = 1'b0;
    logic       retry = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_grant, halt_pull, fault_flag;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    dfault_guard dut_i (
        .clk(clk), .rst_n(rst_n), .exc_start(exc_start), .exc_kind(exc_kind),
        .exc_done(exc_done), .bus_err(bus_err), .addr_err(addr_err),
        .retry(retry), .bus_req(bus_req), .bus_grant(bus_grant),
        .halt_pull(halt_pull), .fault_flag(fault_flag)
    );

    // Behavioural reference: phase, latched fault and grant as plain bits.
    bit m_phase = 1, m_fault = 0, m_grant = 0;
    always @(posedge clk) begin
        bit counted;
        counted = addr_err || (bus_err && !retry);
        if (!rst_n) begin
            m_phase <= 1; m_fault <= 0; m_grant <= 0;
        end else begin
            m_grant <= bus_req;
            if (m_phase && counted) m_fault <= 1;
            if (exc_start && exc_kind != 2'b00) m_phase <= 1;
            else if (exc_done) m_phase <= 0;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done_flag && $time > 0) begin
            chk("R3 model fault", fault_flag, m_fault);
            chk("R8 model halt", halt_pull, m_fault);
            chk("R9 model grant", bus_grant, m_grant);
        end
    end

    task automatic drive(bit st, bit [1:0] k, bit dn, bit be, bit ae, bit rt, bit rq);
        exc_start = st; exc_kind = k; exc_done = dn;
        bus_err = be; addr_err = ae; retry = rt; bus_req = rq;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(3);
        rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state, including a request held during reset.
        rst_n = 0;
        drive(0, 0, 0, 1, 1, 0, 1);
        drive(0, 0, 0, 0, 0, 0, 1);
        chk("R1 fault in reset", fault_flag, 0);
        chk("R1 halt in reset", halt_pull, 0);
        chk("R1 grant in reset", bus_grant, 0);
        rst_n = 1;
        // R2: reset exception armed; error before completion faults.
        drive(0, 0, 0, 0, 1, 0, 0);
        chk("R2 fault after reset-phase error", fault_flag, 1);
        chk("R8 halt with fault", halt_pull, 1);

        // R4: errors after completion are ordinary.
        do_reset();
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        chk("R4 no fault after done", fault_flag, 0);
        chk("R8 no halt after done", halt_pull, 0);

        // R5: other-kind exception does not arm.
        drive(1, 2'b00, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        chk("R5 other kind ignored", fault_flag, 0);

        // R6: long run of retried bus errors inside a bus-error exception.
        drive(1, 2'b01, 0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) drive(0, 0, 0, 1, 0, 1, 0);
        chk("R6 retries not counted", fault_flag, 0);
        // R6: address error counts even with retry high.
        drive(0, 0, 0, 0, 1, 1, 0);
        chk("R6 addr error with retry counts", fault_flag, 1);

        // R7 / R9: sticky fault, arbitration still granted.
        drive(0, 0, 1, 0, 0, 0, 1);
        drive(1, 2'b10, 1, 0, 0, 0, 1);
        chk("R9 grant while halted", bus_grant, 1);
        idle(5);
        chk("R7 fault sticky", fault_flag, 1);
        chk("R9 grant drops", bus_grant, 0);

        // R10: start and done together; start wins.
        do_reset();
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 2'b10, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        chk("R10 start beats done", fault_flag, 1);

        // R10 / R3: error with the start itself not counted, next one is.
        do_reset();
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 2'b11, 0, 1, 0, 0, 0);
        chk("R10 same-cycle error ignored", fault_flag, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        chk("R3 bus error in reset exception", fault_flag, 1);

        // R3: bus-error exception with unretried bus error.
        do_reset();
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 2'b01, 0, 0, 0, 0, 0);
        idle(2);
        chk("R3 armed, no error yet", fault_flag, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        chk("R3 bus error in bus-error exception", fault_flag, 1);

        // R1: reset clears the latched fault.
        rst_n = 0;
        idle(1);
        chk("R1 reset clears fault", fault_flag, 0);
        rst_n = 1;
        idle(2);

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule